// File: doc/BRIEF.md
# Receive FIFO Flow Controller

This block watches how full a 64-entry receive FIFO is and decides when the remote sender must pause and when it may continue. Software programs a halt level and a resume level into one configuration register. A two-bit mode field selects how the block acts. In hardware mode it drives a request-to-send style output. In software mode it asks the local transmitter to send an XOFF or XON character. The mode may also be off.

The two levels form a hysteresis band. After the FIFO reaches the halt level, the block stays in the halted state until the fill level drops to the resume level or below. A request to send a flow-control character stays raised until the transmitter acknowledges it. The transmitter is expected to send that character before any data byte it has queued. The FIFO itself, the serial framing and the baud generation sit outside this block.

Top module: `ufc_flow_ctrl`

## Requirements
- R1: After reset, `rts_ok` is 1, `xo_req` is 0 and the mode is off. The halt field resets to 11 (level 48) and the resume field resets to 4 (level 16).
- R2: A write with `cfg_addr`=0 loads the thresholds. The halt level is (`cfg_wdata[7:4]`+1)*4. The resume level is `cfg_wdata[3:0]`*4. A write with `cfg_addr`=1 loads the mode from `cfg_wdata[1:0]`: 01 selects hardware, 10 selects software, and 00 or 11 selects off.
- R3: When the programmed resume level is at or above the halt level, the block uses the halt level minus one as the resume level.
- R4: In hardware mode, `rts_ok` falls on the clock edge after which `rx_level` has been at or above the halt level.
- R5: In hardware mode, once halted, `rts_ok` stays 0 while `rx_level` is above the resume level. It returns to 1 on the edge after `rx_level` is at or below the resume level.
- R6: In software mode, `rts_ok` stays 1. Reaching the halt level raises `xo_req` with `xo_kind`=1 (XOFF). Falling to the resume level raises `xo_req` with `xo_kind`=0 (XON). Each event raises the request once.
- R7: A raised `xo_req` stays 1 until a cycle with `xo_ack`=1, and is 0 on the following cycle unless a new event arrives in that same cycle.
- R8: In off mode, `rts_ok` is 1 and `xo_req` is 0 whatever the FIFO level.
- R9: A mode write clears the halted state and any pending request. In the cycle after the write, `rts_ok` is 1 and `xo_req` is 0.
- R10: If an event arrives while an earlier request is still pending, the request stays raised and `xo_kind` takes the value of the newer event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 selects the thresholds, 1 selects the mode |
| cfg_wdata | input | 8 | Configuration write data |
| rx_level | input | 7 | Receive FIFO occupancy, 0 to 64 |
| rts_ok | output | 1 | 1 while the remote end may send (hardware mode) |
| xo_req | output | 1 | Request to transmit a flow-control character |
| xo_kind | output | 1 | 1 = XOFF, 0 = XON; valid while `xo_req` is 1 |
| xo_ack | input | 1 | Transmitter has taken the pending request |

## Verification
A wrong halted state appears directly on `rts_ok` in hardware mode one cycle after the level input changes. In software mode the same fault appears as a missing, doubled or wrong-kind request, seen on the edge after the crossing. A bad resume clamp shows as `rts_ok` stuck low, or as a request pattern that toggles, once the FIFO level sits between the two thresholds. A request lost or kept too long becomes visible in the cycle after an acknowledge, or after a new crossing during a pending request. The level is driven as a random walk across both thresholds, so each of these faults shows within a few dozen cycles.

// File: rtl/ufc_pkg.sv
// Shared types for the receive FIFO flow controller.
// Assumes: a two-bit mode field and a one-bit character kind.
package ufc_pkg;

    typedef enum logic [1:0] {
        FC_OFF   = 2'b00,
        FC_HW    = 2'b01,
        FC_SW    = 2'b10,
        FC_OFF_B = 2'b11
    } fc_mode_e;

    localparam logic KIND_XOFF = 1'b1;
    localparam logic KIND_XON  = 1'b0;

endpackage

// File: rtl/ufc_cfg_regs.sv
// Configuration register: holds the two threshold fields and the mode.
// Address 0 carries the halt field in the upper nibble and the resume field
// in the lower nibble. Address 1 carries the mode in bits 1:0.
// Assumes: DATA_W >= 2*FIELD_W.
module ufc_cfg_regs
    import ufc_pkg::*;
#(
    parameter int FIELD_W    = 4,
    parameter int DATA_W     = 8,
    parameter int HALT_RST   = 11,
    parameter int RESUME_RST = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    output logic [FIELD_W-1:0] halt_f,
    output logic [FIELD_W-1:0] resume_f,
    output fc_mode_e           mode,
    output logic               mode_wr
);

    // A mode write is the clear event for the rest of the block.
    assign mode_wr = cfg_we && cfg_addr;

    // Threshold register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_f   <= FIELD_W'(HALT_RST);
            resume_f <= FIELD_W'(RESUME_RST);
        end else if (cfg_we && !cfg_addr) begin
            halt_f   <= cfg_wdata[2*FIELD_W-1:FIELD_W];
            resume_f <= cfg_wdata[FIELD_W-1:0];
        end
    end

    // Mode register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= FC_OFF;
        end else if (mode_wr) begin
            mode <= fc_mode_e'(cfg_wdata[1:0]);
        end
    end

endmodule

// File: rtl/ufc_thresh.sv
// Turns the threshold fields into FIFO levels.
// The halt level is (field+1)*STEP, so it is never zero.
// The resume level is field*STEP, clamped to halt-1 so the band is never empty.
// Assumes: LVL_W can hold (2**FIELD_W)*STEP.
module ufc_thresh #(
    parameter int FIELD_W  = 4,
    parameter int STEP_LOG = 2,
    parameter int LVL_W    = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] halt_f,
    input  logic [FIELD_W-1:0] resume_f,
    output logic [LVL_W-1:0]   halt_lvl,
    output logic [LVL_W-1:0]   resume_lvl
);

    localparam int RAW_W = FIELD_W + 1 + STEP_LOG;

    logic [FIELD_W:0]   halt_p1;
    logic [RAW_W-1:0]   halt_raw;
    logic [LVL_W-1:0]   resume_raw;

    // Scale both fields to FIFO entries.
    always_comb begin
        halt_p1    = {1'b0, halt_f} + (FIELD_W+1)'(1);
        halt_raw   = {halt_p1, {STEP_LOG{1'b0}}};
        halt_lvl   = LVL_W'(halt_raw);
        resume_raw = LVL_W'({resume_f, {STEP_LOG{1'b0}}});
    end

    // Keep the resume level strictly below the halt level.
    always_comb begin
        if (resume_raw >= halt_lvl) begin
            resume_lvl = halt_lvl - LVL_W'(1);
        end else begin
            resume_lvl = resume_raw;
        end
    end

    AST_BAND_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        resume_lvl < halt_lvl); // R3

endmodule

// File: rtl/ufc_hyst.sv
// Hysteresis state: marks the link halted when the level reaches the halt
// level and releases it when the level falls to the resume level or below.
// It gives one-cycle pulses on each change of state for the software path.
// Assumes: resume_lvl < halt_lvl.
module ufc_hyst #(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             clr,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] halt_lvl,
    input  logic [LVL_W-1:0] resume_lvl,
    output logic             halted,
    output logic             go_halt,
    output logic             go_run
);

    logic halted_nxt;

    // Next halted state from the level and the band.
    always_comb begin
        halted_nxt = halted;
        if (clr || !active) begin
            halted_nxt = 1'b0;
        end else if (!halted && (level >= halt_lvl)) begin
            halted_nxt = 1'b1;
        end else if (halted && (level <= resume_lvl)) begin
            halted_nxt = 1'b0;
        end
    end

    // Change-of-state pulses.
    assign go_halt = !halted && halted_nxt;
    assign go_run  = halted && !halted_nxt;

    // Halted state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted <= 1'b0;
        end else begin
            halted <= halted_nxt;
        end
    end

    AST_HALT_ON_REACH: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !clr && (level >= halt_lvl)) |=> halted); // R4
    AST_HOLD_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !clr && halted && (level > resume_lvl)) |=> halted); // R5
    AST_RELEASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && (level <= resume_lvl)) |=> !halted); // R5

endmodule

// File: rtl/ufc_sw_req.sv
// Software flow-control request: raises a request for XOFF or XON on each
// change of state, holds it until the transmitter acknowledges it, and lets
// a newer event replace the kind of a request that is still pending.
// Assumes: go_halt and go_run are never high together.
module ufc_sw_req
    import ufc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic clr,
    input  logic go_halt,
    input  logic go_run,
    input  logic ack,
    output logic req,
    output logic kind
);

    // Request and kind registers; a new event wins over an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req  <= 1'b0;
            kind <= KIND_XON;
        end else if (clr || !enable) begin
            req  <= 1'b0;
        end else if (go_halt) begin
            req  <= 1'b1;
            kind <= KIND_XOFF;
        end else if (go_run) begin
            req  <= 1'b1;
            kind <= KIND_XON;
        end else if (ack) begin
            req  <= 1'b0;
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !clr && req && !ack) |=> req); // R7
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack && !go_halt && !go_run) |=> !req); // R7
    AST_NEWER_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !clr && go_run) |=> (req && (kind == KIND_XON))); // R10

endmodule

// File: rtl/ufc_flow_ctrl.sv
// Receive FIFO flow controller top.
// It compares the FIFO level with the programmed halt and resume levels and
// drives either a send-permission output (hardware mode) or XOFF/XON
// requests to the transmitter (software mode).
// Assumes: rx_level is the current FIFO occupancy, 0 to 64.
module ufc_flow_ctrl
    import ufc_pkg::*;
#(
    parameter int FIELD_W  = 4,
    parameter int STEP_LOG = 2,
    parameter int LVL_W    = 7,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [LVL_W-1:0]  rx_level,
    output logic              rts_ok,
    output logic              xo_req,
    output logic              xo_kind,
    input  logic              xo_ack
);

    logic [FIELD_W-1:0] halt_f;
    logic [FIELD_W-1:0] resume_f;
    fc_mode_e           mode;
    logic               mode_wr;
    logic [LVL_W-1:0]   halt_lvl;
    logic [LVL_W-1:0]   resume_lvl;
    logic               halted;
    logic               go_halt;
    logic               go_run;
    logic               hw_on;
    logic               sw_on;

    // Decode the mode into its two enables.
    assign hw_on = (mode == FC_HW);
    assign sw_on = (mode == FC_SW);

    ufc_cfg_regs #(
        .FIELD_W    (FIELD_W),
        .DATA_W     (DATA_W),
        .HALT_RST   (11),
        .RESUME_RST (4)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .halt_f    (halt_f),
        .resume_f  (resume_f),
        .mode      (mode),
        .mode_wr   (mode_wr)
    );

    ufc_thresh #(
        .FIELD_W  (FIELD_W),
        .STEP_LOG (STEP_LOG),
        .LVL_W    (LVL_W)
    ) i_thresh (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_f     (halt_f),
        .resume_f   (resume_f),
        .halt_lvl   (halt_lvl),
        .resume_lvl (resume_lvl)
    );

    ufc_hyst #(
        .LVL_W (LVL_W)
    ) i_hyst (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (hw_on || sw_on),
        .clr        (mode_wr),
        .level      (rx_level),
        .halt_lvl   (halt_lvl),
        .resume_lvl (resume_lvl),
        .halted     (halted),
        .go_halt    (go_halt),
        .go_run     (go_run)
    );

    ufc_sw_req i_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (sw_on),
        .clr     (mode_wr),
        .go_halt (go_halt),
        .go_run  (go_run),
        .ack     (xo_ack),
        .req     (xo_req),
        .kind    (xo_kind)
    );

    // Send permission drops only for a halted link in hardware mode.
    assign rts_ok = !(hw_on && halted);

    AST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_on |-> !xo_req); // R8
    AST_MODE_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (rts_ok && !xo_req)); // R9
    AST_SW_KEEPS_RTS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_on |-> rts_ok); // R6

endmodule

// File: tb/test_ufc_flow_ctrl.sv
// Self-checking bench: directed corner cases, then a random walk of the FIFO
// level with random writes and acknowledges, compared against a bench model.
module test_ufc_flow_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_addr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [6:0] rx_level = 7'd0;
    logic       rts_ok;
    logic       xo_req;
    logic       xo_kind;
    logic       xo_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Bench model state.
    int m_halt_f = 11;
    int m_res_f = 4;
    int m_mode = 0;
    bit m_stop = 1'b0;
    bit m_req = 1'b0;
    bit m_kind = 1'b0;

    always #5 clk = ~clk;

    ufc_flow_ctrl i_ufc_flow_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .rx_level  (rx_level),
        .rts_ok    (rts_ok),
        .xo_req    (xo_req),
        .xo_kind   (xo_kind),
        .xo_ack    (xo_ack)
    );

    function automatic int halt_level(input int f);
        return (f + 1) * 4;
    endfunction

    function automatic int resume_level(input int hf, input int rf);
        int h = halt_level(hf);
        int r = rf * 4;
        return (r >= h) ? h - 1 : r;
    endfunction

    task automatic chk(input logic got, input logic exp, input string tag, input string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s got=%0b exp=%0b", tag, what, got, exp);
        end
    endtask

    // One clock: drive inputs, advance the model, compare after the edge.
    task automatic step(input int lvl, input bit we, input bit addr,
                        input logic [7:0] data, input bit ack, input string tag);
        int  hl;
        int  re;
        bit  act;
        bit  clr;
        bit  n_stop;
        bit  n_req;
        bit  n_kind;
        rx_level  = 7'(lvl);
        cfg_we    = we;
        cfg_addr  = addr;
        cfg_wdata = data;
        xo_ack    = ack;
        hl  = halt_level(m_halt_f);
        re  = resume_level(m_halt_f, m_res_f);
        act = (m_mode == 1) || (m_mode == 2);
        clr = we && addr;
        n_stop = m_stop;
        if (clr || !act) n_stop = 1'b0;
        else if (!m_stop && lvl >= hl) n_stop = 1'b1;
        else if (m_stop && lvl <= re) n_stop = 1'b0;
        n_req  = m_req;
        n_kind = m_kind;
        if (clr || m_mode != 2) n_req = 1'b0;
        else if (!m_stop && n_stop) begin n_req = 1'b1; n_kind = 1'b1; end
        else if (m_stop && !n_stop) begin n_req = 1'b1; n_kind = 1'b0; end
        else if (ack) n_req = 1'b0;
        @(posedge clk);
        #1;
        m_stop = n_stop;
        m_req  = n_req;
        m_kind = n_kind;
        if (we && !addr) begin
            m_halt_f = int'(data[7:4]);
            m_res_f  = int'(data[3:0]);
        end
        if (we && addr) m_mode = int'(data[1:0]);
        chk(rts_ok, !(m_mode == 1 && m_stop), tag, "rts_ok");
        chk(xo_req, m_req, tag, "xo_req");
        if (m_req) chk(xo_kind, m_kind, tag, "xo_kind");
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int lvl;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state
        chk(rts_ok, 1'b1, "R1", "rts_ok after reset");
        chk(xo_req, 1'b0, "R1", "xo_req after reset");
        // R1 default thresholds 48/16 in hardware mode
        step(0, 1, 1, 8'h01, 0, "R2");
        step(47, 0, 0, 8'h00, 0, "R1");
        step(48, 0, 0, 8'h00, 0, "R4");
        step(30, 0, 0, 8'h00, 0, "R5");
        step(17, 0, 0, 8'h00, 0, "R5");
        step(16, 0, 0, 8'h00, 0, "R5");
        // R2 and R3: halt field 3 (16), resume field 7 (28) clamps to 15
        step(0, 1, 0, 8'h37, 0, "R2");
        step(15, 0, 0, 8'h00, 0, "R2");
        step(16, 0, 0, 8'h00, 0, "R4");
        step(15, 0, 0, 8'h00, 0, "R3");
        // R9: a mode write releases a halted link
        step(20, 0, 0, 8'h00, 0, "R4");
        step(20, 1, 1, 8'h01, 0, "R9");
        step(20, 0, 0, 8'h00, 0, "R4");
        // R6, R7 and R10 in software mode
        step(0, 1, 1, 8'h02, 0, "R9");
        step(16, 0, 0, 8'h00, 0, "R6");
        step(16, 0, 0, 8'h00, 0, "R7");
        step(16, 0, 0, 8'h00, 1, "R7");
        step(10, 0, 0, 8'h00, 0, "R6");
        step(10, 0, 0, 8'h00, 1, "R7");
        step(16, 0, 0, 8'h00, 0, "R6");
        step(5, 0, 0, 8'h00, 0, "R10");
        step(5, 0, 0, 8'h00, 1, "R7");
        // R8: off mode ignores a full FIFO
        step(0, 1, 1, 8'h00, 0, "R9");
        step(64, 0, 0, 8'h00, 0, "R8");
        step(64, 1, 1, 8'h03, 0, "R8");
        step(64, 0, 0, 8'h00, 1, "R8");
        // Random walk across the thresholds
        lvl = 0;
        for (int i = 0; i < 4000; i++) begin
            bit         we;
            bit         addr;
            logic [7:0] data;
            bit         ack;
            string      tag;
            lvl = lvl + int'($urandom_range(0, 8)) - 4;
            if (lvl < 0) lvl = 0;
            if (lvl > 64) lvl = 64;
            we   = ($urandom_range(0, 49) == 0);
            addr = $urandom_range(0, 1) == 1;
            data = 8'($urandom);
            if (we && addr && $urandom_range(0, 3) != 0) data[1:0] = 2'($urandom_range(1, 2));
            ack  = m_req && ($urandom_range(0, 2) == 0);
            tag  = (m_mode == 1) ? "R5" : (m_mode == 2) ? (m_req ? "R7" : "R6") : "R8";
            step(lvl, we, addr, data, ack, tag);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule